// File: doc/BRIEF.md
# Two-Element Weighted Stochastic Synapse

This block is a two-bit learning synapse for a spiking neuron array. It holds two binary weight elements. The long-term element learns only spike pairs that are close together in time and keeps what it learns. The short-term element learns across wider gaps and loses what it learns more quickly. Each element follows its own stochastic timing rule. A flip is allowed only when the element's random sample is below a probability that decays with the spike-time gap.

When a presynaptic spike arrives, the block puts a current contribution on `cur_o` for the neuron's input sum. That contribution is a weighted sum of the two elements. The long-term bit is worth 80 % of full scale and the short-term bit 20 %. A spurious flip of either element therefore adds only part of a full weight. With both bits set, the output equals that of a single fully-on one-bit synapse.

The block tracks spike ages itself from the `pre_spike_i` and `post_spike_i` strobes. Each element draws its own random sample. A seed load can preset both elements before training.

Top module: `lt_st_synapse`

## Requirements
- R1: After reset both weight outputs are 0, `cur_o` is 0 even with a presynaptic spike present, and no earlier spike of either kind is remembered.
- R2: In the same cycle as `pre_spike_i`, `cur_o` = 204·w_lt + 51·w_st, using the weights held before that cycle's update; both set gives 255. `cur_o` is 0 in every cycle without a presynaptic spike.
- R3: A postsynaptic spike dt cycles after the most recent presynaptic spike (1 ≤ dt ≤ 62, no presynaptic spike in the same cycle) sets a cleared element on the next clock edge when its 8-bit random sample is below peak >> (dt >> shift). Defaults: long-term peak 38 with shift 1; short-term peak 38 with shift 3.
- R4: A presynaptic spike dt cycles after the most recent postsynaptic spike (1 ≤ dt ≤ 62, no postsynaptic spike in the same cycle) clears a set element on the next clock edge when its random sample is below peak >> (dt >> shift). Defaults: long-term peak 26 with shift 1; short-term peak 51 with shift 3.
- R5: A gap of 63 or more cycles, or no opposite spike since reset, causes no update.
- R6: A presynaptic and a postsynaptic spike in the same cycle change neither weight. Both spike ages restart from that cycle.
- R7: The long-term element uses only `rnd_lt_i` and the short-term element only `rnd_st_i`, so one element can flip while the other holds in the same cycle.
- R8: With `seed_load_i` high, the next clock edge loads `seed_lt_i` and `seed_st_i` into the weights, overriding any learning event in that cycle.
- R9: A potentiation event on an element that is already set, or a depression event on one that is already cleared, leaves it unchanged whatever the random sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_spike_i | input | 1 | Presynaptic spike strobe |
| post_spike_i | input | 1 | Postsynaptic spike strobe |
| rnd_lt_i | input | 8 | Random sample for the long-term element |
| rnd_st_i | input | 8 | Random sample for the short-term element |
| seed_load_i | input | 1 | Load the seed bits into both weights |
| seed_lt_i | input | 1 | Seed value for the long-term weight |
| seed_st_i | input | 1 | Seed value for the short-term weight |
| w_lt_o | output | 1 | Long-term weight |
| w_st_o | output | 1 | Short-term weight |
| cur_o | output | 8 | Weighted current contribution |

## Verification
The bench builds the block with default parameters, except the short-term potentiation shift, which it raises to 5. At the default shift of 3, the probability has already decayed to zero at a 62-cycle gap, so the window edge could not be seen. With shift 5, a 62-cycle gap still gives a nonzero probability (19), while a 63-cycle gap must give no update. This makes the window boundary in R5 observable. The other settings keep the differing long-term and short-term curves within reach of hand-picked random samples at gaps of 1, 3 and 10 cycles. A long pseudo-random spike and sample stream covers simultaneous events, seed loads and repeated flips.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef struct packed {
    logic pot;
    logic dep;
  } learn_evt_t;

  // halve the peak probability every 2**sh cycles of gap
  function automatic logic [15:0] decay_prob(logic [15:0] peak, int unsigned sh, logic [15:0] dt);
    return peak >> (dt >> sh);
  endfunction
endpackage

// File: rtl/spike_age.sv
module spike_age #(
  parameter int unsigned AGE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spike_i,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_o <= AGE_MAX;
    else if (spike_i)      age_o <= AGE_W'(1);
    else if (age_o != AGE_MAX) age_o <= age_o + AGE_W'(1);
  end

  assert_age_saturates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_o == AGE_MAX && !spike_i) |=> age_o == AGE_MAX);
endmodule

// File: rtl/stdp_element.sv
module stdp_element
  import syn_pkg::*;
#(
  parameter int unsigned AGE_W     = 6,
  parameter int unsigned PROB_W    = 8,
  parameter int unsigned POT_PEAK  = 38,
  parameter int unsigned POT_SHIFT = 1,
  parameter int unsigned DEP_PEAK  = 26,
  parameter int unsigned DEP_SHIFT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  learn_evt_t        evt_i,
  input  logic [AGE_W-1:0]  pot_dt_i,
  input  logic [AGE_W-1:0]  dep_dt_i,
  input  logic [PROB_W-1:0] rnd_i,
  input  logic              seed_load_i,
  input  logic              seed_val_i,
  output logic              w_o
);
  logic [PROB_W-1:0] p_pot, p_dep;
  logic              do_set, do_clr;

  assign p_pot = PROB_W'(decay_prob(16'(POT_PEAK), POT_SHIFT, 16'(pot_dt_i)));
  assign p_dep = PROB_W'(decay_prob(16'(DEP_PEAK), DEP_SHIFT, 16'(dep_dt_i)));

  assign do_set = evt_i.pot && !w_o && (rnd_i < p_pot);
  assign do_clr = evt_i.dep &&  w_o && (rnd_i < p_dep);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          w_o <= 1'b0;
    else if (seed_load_i) w_o <= seed_val_i;
    else if (do_set)      w_o <= 1'b1;
    else if (do_clr)      w_o <= 1'b0;
  end

  assert_set_needs_pot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!w_o && !evt_i.pot && !seed_load_i) |=> !w_o);
  assert_clr_needs_dep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_o && !evt_i.dep && !seed_load_i) |=> w_o);
  assert_seed_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> (w_o == $past(seed_val_i)));
endmodule

// File: rtl/weighted_readout.sv
module weighted_readout #(
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned LT_VAL = 204,
  parameter int unsigned ST_VAL = 51
) (
  input  logic             pre_i,
  input  logic [1:0]       w_i,
  output logic [OUT_W-1:0] cur_o
);
  logic [OUT_W-1:0] lt_part, st_part;

  assign lt_part = w_i[0] ? OUT_W'(LT_VAL) : '0;
  assign st_part = w_i[1] ? OUT_W'(ST_VAL) : '0;
  assign cur_o   = pre_i ? (lt_part + st_part) : '0;
endmodule

// File: rtl/lt_st_synapse.sv
module lt_st_synapse
  import syn_pkg::*;
#(
  parameter int unsigned AGE_W        = 6,
  parameter int unsigned PROB_W       = 8,
  parameter int unsigned OUT_W        = 8,
  parameter int unsigned LT_POT_PEAK  = 38,
  parameter int unsigned LT_POT_SHIFT = 1,
  parameter int unsigned ST_POT_PEAK  = 38,
  parameter int unsigned ST_POT_SHIFT = 3,
  parameter int unsigned LT_DEP_PEAK  = 26,
  parameter int unsigned LT_DEP_SHIFT = 1,
  parameter int unsigned ST_DEP_PEAK  = 51,
  parameter int unsigned ST_DEP_SHIFT = 3,
  parameter int unsigned LT_VAL       = 204,
  parameter int unsigned ST_VAL       = 51
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_spike_i,
  input  logic              post_spike_i,
  input  logic [PROB_W-1:0] rnd_lt_i,
  input  logic [PROB_W-1:0] rnd_st_i,
  input  logic              seed_load_i,
  input  logic              seed_lt_i,
  input  logic              seed_st_i,
  output logic              w_lt_o,
  output logic              w_st_o,
  output logic [OUT_W-1:0]  cur_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam int unsigned N_ELEM = 2;

  logic [AGE_W-1:0]              pre_age, post_age;
  learn_evt_t                    evt;
  logic [N_ELEM-1:0][PROB_W-1:0] rnd_vec;
  logic [N_ELEM-1:0]             seed_vec, w_vec;

  spike_age #(.AGE_W(AGE_W)) u_pre_age (
    .clk_i, .rst_ni, .spike_i(pre_spike_i), .age_o(pre_age));
  spike_age #(.AGE_W(AGE_W)) u_post_age (
    .clk_i, .rst_ni, .spike_i(post_spike_i), .age_o(post_age));

  // same-cycle pair has zero gap: neither rule applies
  assign evt.pot = post_spike_i && !pre_spike_i && (pre_age  != AGE_MAX);
  assign evt.dep = pre_spike_i  && !post_spike_i && (post_age != AGE_MAX);

  assign rnd_vec  = {rnd_st_i, rnd_lt_i};
  assign seed_vec = {seed_st_i, seed_lt_i};

  for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
    localparam int unsigned PP = (g == 0) ? LT_POT_PEAK  : ST_POT_PEAK;
    localparam int unsigned PS = (g == 0) ? LT_POT_SHIFT : ST_POT_SHIFT;
    localparam int unsigned DP = (g == 0) ? LT_DEP_PEAK  : ST_DEP_PEAK;
    localparam int unsigned DS = (g == 0) ? LT_DEP_SHIFT : ST_DEP_SHIFT;
    stdp_element #(
      .AGE_W(AGE_W), .PROB_W(PROB_W),
      .POT_PEAK(PP), .POT_SHIFT(PS), .DEP_PEAK(DP), .DEP_SHIFT(DS)
    ) u_el (
      .clk_i, .rst_ni,
      .evt_i(evt),
      .pot_dt_i(pre_age),
      .dep_dt_i(post_age),
      .rnd_i(rnd_vec[g]),
      .seed_load_i,
      .seed_val_i(seed_vec[g]),
      .w_o(w_vec[g])
    );
  end

  weighted_readout #(.OUT_W(OUT_W), .LT_VAL(LT_VAL), .ST_VAL(ST_VAL)) u_read (
    .pre_i(pre_spike_i), .w_i(w_vec), .cur_o(cur_o));

  assign w_lt_o = w_vec[0];
  assign w_st_o = w_vec[1];

  assert_coincident_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_spike_i && post_spike_i && !seed_load_i) |=> ($stable(w_lt_o) && $stable(w_st_o)));
endmodule

// File: tb/tb_lt_st_synapse.sv
module tb_lt_st_synapse;
  localparam int LP_PK = 38, LP_SH = 1, SP_PK = 38, SP_SH = 5;
  localparam int LD_PK = 26, LD_SH = 1, SD_PK = 51, SD_SH = 3;
  localparam int WIN = 63;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       pre_spike_i = 0, post_spike_i = 0, seed_load_i = 0, seed_lt_i = 0, seed_st_i = 0;
  logic [7:0] rnd_lt_i = 8'hff, rnd_st_i = 8'hff;
  logic       w_lt_o, w_st_o;
  logic [7:0] cur_o;

  int errors = 0, checks = 0;
  int m_pre_age = WIN, m_post_age = WIN, m_wl = 0, m_ws = 0;

  always #5 clk_i = ~clk_i;

  lt_st_synapse #(.ST_POT_SHIFT(SP_SH)) dut (
    .clk_i, .rst_ni, .pre_spike_i, .post_spike_i, .rnd_lt_i, .rnd_st_i,
    .seed_load_i, .seed_lt_i, .seed_st_i, .w_lt_o, .w_st_o, .cur_o);

  function automatic int prob(int peak, int sh, int dt);
    return peak >> (dt >> sh);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int nl = m_wl, ns = m_ws;
    if (seed_load_i) begin
      nl = seed_lt_i; ns = seed_st_i;
    end else if (post_spike_i && !pre_spike_i && m_pre_age < WIN) begin
      if (m_wl == 0 && rnd_lt_i < prob(LP_PK, LP_SH, m_pre_age)) nl = 1;
      if (m_ws == 0 && rnd_st_i < prob(SP_PK, SP_SH, m_pre_age)) ns = 1;
    end else if (pre_spike_i && !post_spike_i && m_post_age < WIN) begin
      if (m_wl == 1 && rnd_lt_i < prob(LD_PK, LD_SH, m_post_age)) nl = 0;
      if (m_ws == 1 && rnd_st_i < prob(SD_PK, SD_SH, m_post_age)) ns = 0;
    end
    m_wl = nl; m_ws = ns;
    m_pre_age  = pre_spike_i  ? 1 : (m_pre_age  < WIN ? m_pre_age  + 1 : WIN);
    m_post_age = post_spike_i ? 1 : (m_post_age < WIN ? m_post_age + 1 : WIN);
  endtask

  // drive just after an edge, check current mid-cycle, update model, check weights after edge
  task automatic cyc(bit pre, bit post, int rl, int rs, bit sl = 0, bit sv_l = 0, bit sv_s = 0);
    pre_spike_i = pre; post_spike_i = post;
    rnd_lt_i = 8'(rl); rnd_st_i = 8'(rs);
    seed_load_i = sl; seed_lt_i = sv_l; seed_st_i = sv_s;
    #3;
    chk("R2 cur", int'(cur_o), pre ? (204 * m_wl + 51 * m_ws) : 0);
    @(posedge clk_i);
    model_step();
    #1;
    chk("R3/R4 w_lt", int'(w_lt_o), m_wl);
    chk("R3/R4 w_st", int'(w_st_o), m_ws);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 255, 255);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hace1;
    #12 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 w_lt reset", int'(w_lt_o), 0);
    chk("R1 w_st reset", int'(w_st_o), 0);
    // R5: no earlier presynaptic spike since reset
    cyc(0, 1, 0, 0);
    chk("R5 no history lt", int'(w_lt_o), 0);
    chk("R5 no history st", int'(w_st_o), 0);
    cyc(1, 0, 255, 255);
    chk("R1 cur zero weights", int'(cur_o), 0);
    // R3 dt=3: lt p=19, st p=38
    idle(2);
    cyc(0, 1, 18, 37);
    chk("R3 lt set dt3", int'(w_lt_o), 1);
    chk("R3 st set dt3", int'(w_st_o), 1);
    pre_spike_i = 1; #2;
    chk("R2 full scale", int'(cur_o), 255);
    @(posedge clk_i); model_step(); #1;
    // R6 coincident, rnd 0
    cyc(1, 1, 0, 0);
    chk("R6 lt held", int'(w_lt_o), 1);
    chk("R6 st held", int'(w_st_o), 1);
    // R4 dt=10: lt p=0, st p=25; R7 split outcome
    cyc(0, 1, 255, 255);
    idle(9);
    cyc(1, 0, 0, 24);
    chk("R4 lt kept p0", int'(w_lt_o), 1);
    chk("R7 st cleared", int'(w_st_o), 0);
    cyc(1, 0, 255, 255);
    chk("R2 lt only", int'(cur_o), 204);
    // R9 potentiation on set lt with rnd 0
    cyc(0, 1, 0, 255);
    chk("R9 lt unchanged", int'(w_lt_o), 1);
    // R5 window: dt=63 no update, dt=62 updates
    cyc(1, 0, 255, 255);
    idle(62);
    cyc(0, 1, 0, 0);
    chk("R5 dt63 st", int'(w_st_o), 0);
    cyc(1, 0, 255, 255);
    idle(61);
    cyc(0, 1, 255, 18);
    chk("R5 dt62 st set", int'(w_st_o), 1);
    // R8 seed overrides a learning event
    cyc(1, 0, 255, 255);
    cyc(0, 1, 0, 0, 1, 0, 0);
    chk("R8 seed lt", int'(w_lt_o), 0);
    chk("R8 seed st", int'(w_st_o), 0);
    cyc(0, 0, 255, 255, 1, 1, 0);
    chk("R8 seed lt1", int'(w_lt_o), 1);
    // mixed stream
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & lfsr[3], lfsr[5] & lfsr[7], int'(lfsr[13:8] & 6'h3f),
          int'(lfsr[11:6] & 6'h3f), (lfsr[15:9] == 7'h5a), lfsr[2], lfsr[4]);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule